// File: doc/BRIEF.md
# Colour Subcarrier Oscillator with Burst Window

This block produces the running colour subcarrier phase for an analogue TV encoder. A 32-bit phase accumulator advances by a programmable step on every enabled pixel clock and wraps modulo 2^32. The upper bits of the accumulator are presented as the phase word for a downstream sine table. The step is written four bits at a time through a small write port into eight slots. It is staged in a shadow copy and only becomes live once every slot has been written, so the accumulator never runs on a half-updated step. Example steps are 651,209,077 for a 3.579545 MHz carrier and 520,967,262 for another raster mode. A field-start strobe can zero the accumulator when enabled, which fixes the carrier phase relative to the frame.

The block also opens a burst window on each line. A horizontal sync strobe starts a programmable delay counted in clocks. After the delay the window opens. It stays open until the accumulator has wrapped a set number of times: 9 carrier cycles for the 525-line standard or 10 for the 625-line standard, chosen by a select bit.

Top module: `subcarrier_nco`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `phase_out` is 0 and `burst_gate` is low. The live step after reset is 651,209,077.
- R2: On each rising clock edge with `pix_en` high, the accumulator becomes (accumulator + live step) mod 2^32. `phase_out` shows accumulator bits [31:22].
- R3: With `pix_en` low, the accumulator and `phase_out` hold their value.
- R4: `field_start` sampled high with `phase_reset_en` high sets the accumulator to 0 at that edge, whatever the value of `pix_en`. With `phase_reset_en` low, `field_start` has no effect.
- R5: Write slot s (0..7) carries step bits [31-4s:28-4s]. Slot 0 is bits [31:28] and slot 7 is bits [3:0].
- R6: The staged step becomes live at the edge that completes a set of writes covering all eight slots, in any order. Repeated writes to one slot count once. The add at that same edge still uses the old step. With fewer than eight distinct slots written, the old step stays in use.
- R7: With `burst_delay` = D, `burst_gate` rises at the (D+1)-th rising edge after the edge that samples `hsync_start`.
- R8: The gate falls at the edge of the 9th accumulator wrap (`pal_sel` = 0) or the 10th wrap (`pal_sel` = 1) counted after opening. A wrap on the opening edge is not counted. `pal_sel` is sampled together with `hsync_start`.
- R9: `hsync_start` restarts the delay at any time. If the gate is open, it is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Advance the accumulator this cycle |
| wr_en | input | 1 | Write strobe for one step slot |
| wr_slot | input | 3 | Slot index, 0 = most significant nibble |
| wr_nibble | input | 4 | Nibble value to write |
| field_start | input | 1 | Field-start strobe |
| phase_reset_en | input | 1 | Allow the field-start strobe to zero the accumulator |
| hsync_start | input | 1 | Line sync strobe that starts the burst delay |
| burst_delay | input | 8 | Clocks from the sync strobe to the window opening, minus one |
| pal_sel | input | 1 | 1 = ten-cycle burst, 0 = nine-cycle burst |
| phase_out | output | 10 | Upper accumulator bits for the sine table |
| burst_gate | output | 1 | Burst window |

## Verification
The assertions take the strobes as plain level inputs sampled on each edge and make no demand on their spacing. The burst-close property does assume that the gate closes for only two reasons: a counted wrap or a fresh sync strobe. The bench holds `pix_en` high during every burst trial, so the wrap count can be derived from the product of step and cycle index. It starts each trial with the field and sync strobes on the same edge, so that the accumulator phase at the opening is known exactly. Step changes are always completed with all eight slots before a trial begins.

// File: rtl/scnco_pkg.sv
package scnco_pkg;
  // Burst window sequencer states
  typedef enum logic [1:0] {
    BG_IDLE  = 2'd0,
    BG_DELAY = 2'd1,
    BG_OPEN  = 2'd2
  } bg_state_e;

  // Step used after reset: 3.579545 MHz carrier at the default raster
  localparam logic [31:0] DEFAULT_STEP = 32'd651209077;
endpackage

// File: rtl/scnco_step_regs.sv
// Nibble-wide step slots with shadow staging and an all-slots commit.
module scnco_step_regs #(
  parameter int          ACC_W      = 32,
  parameter int          NIB_W      = 4,
  parameter logic [31:0] RESET_STEP = 32'd651209077,
  localparam int         SLOTS      = ACC_W / NIB_W,
  localparam int         SLOT_AW    = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_slot,
  input  logic [NIB_W-1:0]   wr_nibble,
  output logic [ACC_W-1:0]   step_o,
  output logic               commit_o
);
  logic [ACC_W-1:0] shadow_q, shadow_next, live_q;
  logic [SLOTS-1:0] seen_q, seen_next, slot_hit;

  // One nibble lane per slot; slot 0 is the most significant nibble
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LO = ACC_W - NIB_W * (s + 1);
    assign slot_hit[s] = wr_en && (wr_slot == SLOT_AW'(s));
    assign shadow_next[LO +: NIB_W] = slot_hit[s] ? wr_nibble : shadow_q[LO +: NIB_W];
  end

  assign seen_next = seen_q | slot_hit;
  assign commit_o  = wr_en && (&seen_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= ACC_W'(RESET_STEP);
      live_q   <= ACC_W'(RESET_STEP);
      seen_q   <= '0;
    end else begin
      shadow_q <= shadow_next;
      if (commit_o) begin
        live_q <= shadow_next;
        seen_q <= '0;
      end else begin
        seen_q <= seen_next;
      end
    end
  end

  assign step_o = live_q;
endmodule

// File: rtl/scnco_phase_acc.sv
// Phase accumulator with field-aligned zeroing and a wrap event.
module scnco_phase_acc #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               field_start,
  input  logic               phase_reset_en,
  input  logic [ACC_W-1:0]   step_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               wrap_o,
  output logic [PHASE_W-1:0] phase_o
);
  // Carry-extended sum: the top bit flags a wrap through 2^ACC_W
  function automatic logic [ACC_W:0] nco_sum(input logic [ACC_W-1:0] a,
                                             input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             zero_req;

  assign sum      = nco_sum(acc_q, step_i);
  assign zero_req = field_start && phase_reset_en;
  assign wrap_o   = pix_en && !zero_req && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (zero_req) acc_q <= '0;
    else if (pix_en)   acc_q <= sum[ACC_W-1:0];
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/scnco_burst_gate.sv
// Line burst window: delay in clocks, length in accumulator wraps.
module scnco_burst_gate
  import scnco_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int NTSC_CYCLES = 9,
  parameter int PAL_CYCLES  = 10,
  localparam int MAX_CYC    = (PAL_CYCLES > NTSC_CYCLES) ? PAL_CYCLES : NTSC_CYCLES,
  localparam int CNT_W      = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_start,
  input  logic             pal_sel,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             wrap_i,
  output logic             gate_o
);
  function automatic logic [CNT_W-1:0] cycle_target(input logic pal);
    return pal ? CNT_W'(PAL_CYCLES) : CNT_W'(NTSC_CYCLES);
  endfunction

  bg_state_e        state_q;
  logic [DLY_W-1:0] dly_q;
  logic [CNT_W-1:0] cyc_q, target_q;
  logic             last_wrap;

  assign last_wrap = wrap_i && ((cyc_q + CNT_W'(1)) == target_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= BG_IDLE;
      dly_q    <= '0;
      cyc_q    <= '0;
      target_q <= CNT_W'(NTSC_CYCLES);
    end else if (hsync_start) begin
      state_q  <= BG_DELAY;
      dly_q    <= delay_i;
      cyc_q    <= '0;
      target_q <= cycle_target(pal_sel);
    end else begin
      case (state_q)
        BG_DELAY: begin
          if (dly_q == '0) begin
            state_q <= BG_OPEN;
            cyc_q   <= '0;
          end else begin
            dly_q <= dly_q - DLY_W'(1);
          end
        end
        BG_OPEN: begin
          if (wrap_i) cyc_q <= cyc_q + CNT_W'(1);
          if (last_wrap) state_q <= BG_IDLE;
        end
        default: state_q <= BG_IDLE;
      endcase
    end
  end

  assign gate_o = (state_q == BG_OPEN);
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco #(
  parameter int          ACC_W       = 32,
  parameter int          NIB_W       = 4,
  parameter int          PHASE_W     = 10,
  parameter int          DLY_W       = 8,
  parameter int          NTSC_CYCLES = 9,
  parameter int          PAL_CYCLES  = 10,
  parameter logic [31:0] RESET_STEP  = scnco_pkg::DEFAULT_STEP,
  localparam int         SLOTS       = ACC_W / NIB_W,
  localparam int         SLOT_AW     = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_slot,
  input  logic [NIB_W-1:0]   wr_nibble,
  input  logic               field_start,
  input  logic               phase_reset_en,
  input  logic               hsync_start,
  input  logic [DLY_W-1:0]   burst_delay,
  input  logic               pal_sel,
  output logic [PHASE_W-1:0] phase_out,
  output logic               burst_gate
);
  // Named internal events, observed by the bound checker
  logic [ACC_W-1:0] live_step;
  logic             step_commit;
  logic [ACC_W-1:0] acc_word;
  logic             acc_wrap;

  scnco_step_regs #(
    .ACC_W(ACC_W), .NIB_W(NIB_W), .RESET_STEP(RESET_STEP)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_nibble(wr_nibble), .step_o(live_step), .commit_o(step_commit)
  );

  scnco_phase_acc #(
    .ACC_W(ACC_W), .PHASE_W(PHASE_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_start(field_start),
    .phase_reset_en(phase_reset_en), .step_i(live_step), .acc_o(acc_word),
    .wrap_o(acc_wrap), .phase_o(phase_out)
  );

  scnco_burst_gate #(
    .DLY_W(DLY_W), .NTSC_CYCLES(NTSC_CYCLES), .PAL_CYCLES(PAL_CYCLES)
  ) u_burst (
    .clk(clk), .rst_n(rst_n), .hsync_start(hsync_start), .pal_sel(pal_sel),
    .delay_i(burst_delay), .wrap_i(acc_wrap), .gate_o(burst_gate)
  );
endmodule

// File: rtl/scnco_checker.sv
module scnco_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             field_start,
  input logic             phase_reset_en,
  input logic             hsync_start,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] step,
  input logic             commit,
  input logic             wrap,
  input logic             burst_gate
);
  a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !(field_start && phase_reset_en)) |=> (acc == ACC_W'($past(acc) + $past(step))));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !(field_start && phase_reset_en)) |=> $stable(acc));

  a_r4_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && phase_reset_en) |=> (acc == '0));

  a_r6_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(step));

  a_r8_close_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_gate) |-> ($past(wrap) || $past(hsync_start)));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_start |=> !burst_gate);
endmodule

bind subcarrier_nco scnco_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_start(field_start),
  .phase_reset_en(phase_reset_en), .hsync_start(hsync_start),
  .acc(acc_word), .step(live_step), .commit(step_commit), .wrap(acc_wrap),
  .burst_gate(burst_gate)
);

// File: tb/subcarrier_nco_tb.sv
module subcarrier_nco_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, wr_en, field_start, phase_reset_en, hsync_start, pal_sel;
  logic [2:0] wr_slot;
  logic [3:0] wr_nibble;
  logic [7:0] burst_delay;
  logic [9:0] phase_out;
  logic       burst_gate;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 0;
  longint unsigned cur_step;

  always #5 clk = ~clk;

  subcarrier_nco u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_nibble(wr_nibble), .field_start(field_start), .phase_reset_en(phase_reset_en),
    .hsync_start(hsync_start), .burst_delay(burst_delay), .pal_sel(pal_sel),
    .phase_out(phase_out), .burst_gate(burst_gate)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input longint unsigned act, input longint unsigned exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Phase after k steps from zero, top ten bits of a 32-bit word
  function automatic longint unsigned exp_phase(input longint unsigned k, input longint unsigned st);
    return ((k * st) & 64'hFFFF_FFFF) >> 22;
  endfunction

  // Number of 2^32 crossings after k steps from zero
  function automatic longint unsigned wraps(input longint unsigned k, input longint unsigned st);
    return (k * st) >> 32;
  endfunction

  task automatic write_slot(input int s, input longint unsigned val);
    wr_en = 1'b1;
    wr_slot = 3'(s);
    wr_nibble = 4'((val >> (28 - 4 * s)) & 64'hF);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic load_step(input longint unsigned val);
    for (int s = 0; s < 8; s++) write_slot(s, val);
    cur_step = val;
  endtask

  // Zero the accumulator at one edge (R4)
  task automatic align();
    field_start = 1'b1;
    phase_reset_en = 1'b1;
    tick();
    field_start = 1'b0;
  endtask

  task automatic phase_run(input int n, input longint unsigned st, input string req);
    for (int k = 1; k <= n; k++) begin
      tick();
      check(phase_out, exp_phase(k, st), req);
    end
  endtask

  // R7/R8 trial: field zero and sync strobe on the same edge
  task automatic burst_trial(input int d, input bit pal);
    longint unsigned target, base, per, limit, e;
    target = pal ? 10 : 9;
    per = (64'h1_0000_0000 / cur_step) + 1;
    limit = d + 4 + (target + 1) * per;
    field_start = 1'b1; phase_reset_en = 1'b1;
    hsync_start = 1'b1; pal_sel = pal; burst_delay = 8'(d);
    tick();
    field_start = 1'b0; hsync_start = 1'b0;
    check(burst_gate, 0, "R7 closed at sync edge");
    base = wraps(d + 1, cur_step);
    for (longint unsigned m = 1; m <= limit; m++) begin
      tick();
      e = (m >= d + 1 && (wraps(m, cur_step) - base) < target) ? 1 : 0;
      check(burst_gate, e, pal ? "R8 ten-cycle window" : "R7/R8 nine-cycle window");
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; wr_en = 1'b0; wr_slot = '0; wr_nibble = '0;
    field_start = 1'b0; phase_reset_en = 1'b0; hsync_start = 1'b0;
    burst_delay = '0; pal_sel = 1'b0;
    cur_step = 651209077;
    tick(); tick();
    check(phase_out, 0, "R1 phase in reset");
    check(burst_gate, 0, "R1 gate in reset");
    rst_n = 1'b1;
    tick();
    check(phase_out, 0, "R1 phase after reset");
    check(burst_gate, 0, "R1 gate after reset");

    // R1/R2: default step from zero
    pix_en = 1'b1;
    phase_run(40, 651209077, "R1/R2 default step");

    // R3: hold with pix_en low, then resume
    align();
    phase_run(3, cur_step, "R2 after align");
    pix_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(phase_out, exp_phase(3, cur_step), "R3 hold");
    end
    pix_en = 1'b1;
    tick();
    check(phase_out, exp_phase(4, cur_step), "R3 resume");

    // R4: field strobe ignored when disabled
    field_start = 1'b1; phase_reset_en = 1'b0;
    tick();
    field_start = 1'b0;
    check(phase_out, exp_phase(5, cur_step), "R4 ignored strobe");
    // R4: zeroing wins even with pix_en low
    pix_en = 1'b0;
    align();
    check(phase_out, 0, "R4 zero with pix_en low");
    pix_en = 1'b1;

    // R6: partial writes leave old step live
    for (int s = 7; s >= 1; s--) write_slot(s, 520967262);
    write_slot(3, 520967262);
    align();
    phase_run(20, 651209077, "R6 partial keeps old step");
    write_slot(0, 520967262);
    cur_step = 520967262;
    align();
    phase_run(20, 520967262, "R5/R6 committed step");

    // R5: nibble placement seen through a slot-asymmetric step
    load_step(64'h0010_0000);
    align();
    phase_run(12, cur_step, "R5 low slot placement");
    load_step(64'h4000_0000);
    align();
    phase_run(6, cur_step, "R5 top slot placement");

    // R7/R8 sweep over steps, delays and standards
    foreach (int_steps[i]) begin
      load_step(int_steps[i]);
      for (int d = 0; d < 4; d++) begin
        burst_trial(d, 1'b0);
        burst_trial(d, 1'b1);
      end
    end

    // R9: restart while the window is open
    load_step(64'h4000_0000);
    burst_trial(2, 1'b1);
    field_start = 1'b1; phase_reset_en = 1'b1;
    hsync_start = 1'b1; burst_delay = 8'd2;
    tick();
    field_start = 1'b0; hsync_start = 1'b0;
    for (int m = 1; m <= 4; m++) tick();
    check(burst_gate, 1, "R9 open before restart");
    hsync_start = 1'b1; burst_delay = 8'd1;
    tick();
    hsync_start = 1'b0;
    check(burst_gate, 0, "R9 closed at restart edge");
    tick();
    check(burst_gate, 0, "R9 delay after restart");
    tick();
    check(burst_gate, 1, "R9 reopen after delay");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  longint unsigned int_steps [3] = '{64'h4000_0000, 64'h1C00_0000, 64'h5555_5555};
endmodule